// File: doc/BRIEF.md
# Clock Mode Controller with Write Lock

This block sets the operating clock state of a system. A single configuration register selects either full-speed operation or one of two reduced-speed modes, which differ in whether the PLL stays powered. In the reduced modes a programmable reload counter divides the input clock and produces a one-cycle clock-enable pulse. The block drives the resulting clock enable, a PLL power enable, a real-time-clock source select and a power-down port-driver control.

A lock status input from the oscillator and PLL is synchronized and shown as a read-only register bit. When the PLL is off and software asks for full speed again, the block stays on the divided clock and turns the PLL back on. It selects the fast clock only once the lock status reads 1. A one-shot end-of-initialization strobe freezes the register until the next reset. Two clock-source bits survive the ordinary reset and are cleared only by power-on reset.

Register layout, used by every requirement below: bits [1:0] clock state (00 full speed, 01 slowdown with PLL on, 10 slowdown with PLL off, 11 reserved), bit 2 RTC source select, bit 3 secondary clock source, bits [5:4] power-down field, bit 6 lock status (read-only), bit 7 reads 0, bits [8+RELOAD_W-1:8] reload value.

Top module: `clkmode_ctrl`

## Requirements
- R1: After power-on reset the register reads the clock state 00, power-down field 00, RTC and secondary bits 0, and a reload of RELOAD_RST (3). pll_en is 1, clk_en is 1 on every cycle and wr_locked is 0.
- R2: A write with clock state 11 leaves the clock state unchanged, while its other fields are stored.
- R3: pll_en is 0 exactly when the stored clock state is 10.
- R4: After a change from state 10 to 00, clk_en keeps the divided pulse pattern until the synchronized lock status reads 1. After that, clk_en is 1 on every cycle.
- R5: In states 01 and 10, clk_en pulses once every (reload + 1) cycles, and a reload of 0 gives a pulse on every cycle.
- R6: Bit 6 follows lock_in after SYNC_STAGES (2) clock edges, and writes to bit 6 have no effect.
- R7: A write in the same cycle as init_done is stored. From the next cycle, wr_locked is 1 and all writes are dropped.
- R8: rst_n clears the lock, the clock state, the power-down field and the reload value, but keeps bits 2 and 3. por_n clears everything.
- R9: rtc_async_sel follows bit 2, and pd_ports_off follows bit 4, the low bit of the power-down field.
- R10: After a write of state 00 from state 01, clk_en is 1 on every cycle from the second cycle on, without waiting for lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived input clock |
| por_n | input | 1 | Power-on reset, active low, clears every field |
| rst_n | input | 1 | System reset, active low, keeps the clock-source bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8+RELOAD_W | Register write value |
| init_done | input | 1 | End-of-initialization strobe |
| lock_in | input | 1 | Oscillator stable and PLL locked |
| rd_data | output | 8+RELOAD_W | Register read value |
| clk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL power enable |
| rtc_async_sel | output | 1 | RTC source: 0 CPU clock, 1 oscillator reference |
| pd_ports_off | output | 1 | Turn port drivers off in power-down |
| wr_locked | output | 1 | Register is write-protected |

## Verification
A register write and the end-of-initialization strobe can land on the same clock edge. The bench drives both in one cycle and reads back the written value to confirm the write was kept. It then confirms that a later write is dropped. The change from state 10 to 00 and the arrival of lock can also overlap. The bench holds lock low, counts the divided pulses, raises lock and counts a full run of enables.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   typedef enum logic [1:0] {
      CS_FAST       = 2'b00,
      CS_SLOW_PLL   = 2'b01,
      CS_SLOW_NOPLL = 2'b10,
      CS_RSVD       = 2'b11
   } csel_e;

   typedef enum logic [1:0] {
      M_FAST,
      M_SLOW_PLL,
      M_SLOW_NOPLL,
      M_RELOCK
   } mode_e;

   localparam int CSEL_LSB = 0;
   localparam int RCS_BIT  = 2;
   localparam int SCS_BIT  = 3;
   localparam int PD_LSB   = 4;
   localparam int LOCK_BIT = 6;
   localparam int RSV_BIT  = 7;
   localparam int RLD_LSB  = 8;

endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("clkmode_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               sh[i] <= sh[i-1];
            end
         end
      end
      assign q = sh[STAGES-1];
   end

endmodule

// File: rtl/clkmode_csr.sv
module clkmode_csr
   import clkmode_pkg::*;
#(
   parameter int RELOAD_W   = 8,
   parameter int RELOAD_RST = 3,
   localparam int DATA_W    = RLD_LSB + RELOAD_W
) (
   input  logic                clk,
   input  logic                sys_rst_n,
   input  logic                por_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                init_done,
   input  logic                lock_st,
   output csel_e               csel,
   output logic                rcs,
   output logic [1:0]          pd,
   output logic [RELOAD_W-1:0] reload,
   output logic                locked,
   output logic [DATA_W-1:0]   rd_data
);

   if (RELOAD_W < 1 || RELOAD_W > 16) begin : g_bad_width
      $error("clkmode_csr: RELOAD_W must be 1..16");
   end
   if (RELOAD_RST < 0 || RELOAD_RST >= (1 << RELOAD_W)) begin : g_bad_rst
      $error("clkmode_csr: RELOAD_RST does not fit RELOAD_W");
   end

   localparam logic [RELOAD_W-1:0] RLD_INIT = RELOAD_W'(RELOAD_RST);

   logic wr_ok;
   logic scs;
   logic unused_wr;

   assign wr_ok     = wr_en && !locked;
   assign unused_wr = ^wr_data[RSV_BIT:LOCK_BIT];

   // Fields that only a power-on reset clears
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rcs <= 1'b0;
         scs <= 1'b0;
      end else if (wr_ok) begin
         rcs <= wr_data[RCS_BIT];
         scs <= wr_data[SCS_BIT];
      end
   end

   // Fields cleared by any reset
   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         csel   <= CS_FAST;
         pd     <= 2'b00;
         reload <= RLD_INIT;
         locked <= 1'b0;
      end else begin
         if (wr_ok) begin
            if (csel_e'(wr_data[CSEL_LSB +: 2]) != CS_RSVD) begin
               csel <= csel_e'(wr_data[CSEL_LSB +: 2]);
            end
            pd     <= wr_data[PD_LSB +: 2];
            reload <= wr_data[RLD_LSB +: RELOAD_W];
         end
         if (init_done) begin
            locked <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_data                      = '0;
      rd_data[CSEL_LSB +: 2]       = csel;
      rd_data[RCS_BIT]             = rcs;
      rd_data[SCS_BIT]             = scs;
      rd_data[PD_LSB +: 2]         = pd;
      rd_data[LOCK_BIT]            = lock_st;
      rd_data[RLD_LSB +: RELOAD_W] = reload;
   end

endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload,
   output logic         tick
);

   if (W < 1) begin : g_bad_w
      $error("clkmode_div: W must be positive");
   end

   logic [W-1:0] cnt;

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= reload;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
   import clkmode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  csel_e csel,
   input  logic  lock_st,
   output logic  fast_sel,
   output logic  relock,
   output logic  pll_en
);

   mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (csel)
         CS_FAST: begin
            if (mode_q == M_SLOW_NOPLL || mode_q == M_RELOCK) begin
               mode_d = lock_st ? M_FAST : M_RELOCK;
            end else begin
               mode_d = M_FAST;
            end
         end
         CS_SLOW_PLL:   mode_d = M_SLOW_PLL;
         CS_SLOW_NOPLL: mode_d = M_SLOW_NOPLL;
         default:       mode_d = mode_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_FAST;
      end else begin
         mode_q <= mode_d;
      end
   end

   assign fast_sel = (mode_q == M_FAST);
   assign relock   = (mode_q == M_RELOCK);
   assign pll_en   = (csel != CS_SLOW_NOPLL);

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int RELOAD_W    = 8,
   parameter int RELOAD_RST  = 3,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W     = RLD_LSB + RELOAD_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              init_done,
   input  logic              lock_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              clk_en,
   output logic              pll_en,
   output logic              rtc_async_sel,
   output logic              pd_ports_off,
   output logic              wr_locked
);

   logic                sys_rst_n;
   logic                lock_st;
   csel_e               csel;
   logic [1:0]          pd;
   logic [RELOAD_W-1:0] reload;
   logic                div_tick;
   logic                fast_sel;
   logic                relock;

   assign sys_rst_n = rst_n & por_n;

   clkmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .d     (lock_in),
      .q     (lock_st)
   );

   clkmode_csr #(.RELOAD_W(RELOAD_W), .RELOAD_RST(RELOAD_RST)) u_csr (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .por_n     (por_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .init_done (init_done),
      .lock_st   (lock_st),
      .csel      (csel),
      .rcs       (rtc_async_sel),
      .pd        (pd),
      .reload    (reload),
      .locked    (wr_locked),
      .rd_data   (rd_data)
   );

   clkmode_div #(.W(RELOAD_W)) u_div (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .reload (reload),
      .tick   (div_tick)
   );

   clkmode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .csel     (csel),
      .lock_st  (lock_st),
      .fast_sel (fast_sel),
      .relock   (relock),
      .pll_en   (pll_en)
   );

   assign clk_en       = fast_sel | div_tick;
   assign pd_ports_off = pd[0];

endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk
   import clkmode_pkg::*;
#(
   parameter int RELOAD_W = 8,
   localparam int DATA_W  = RLD_LSB + RELOAD_W
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              clk_en,
   input logic              pll_en,
   input logic              wr_locked,
   input logic              fast_sel,
   input logic              relock,
   input logic              lock_st,
   input logic              div_tick
);

   p_no_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      rd_data[1:0] != 2'b11);

   p_pll_off_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      !pll_en |-> rd_data[1:0] == 2'b10);

   p_relock_wait_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      ($past(relock) && fast_sel) |-> $past(lock_st));

   p_div_gap_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (div_tick && rd_data[RLD_LSB +: RELOAD_W] != '0) |=> !div_tick);

   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      wr_locked |=> wr_locked);

   p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      wr_locked |=> (rd_data[5:0] == $past(rd_data[5:0]) &&
                     rd_data[DATA_W-1:RLD_LSB] == $past(rd_data[DATA_W-1:RLD_LSB])));

   p_fast_en_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      fast_sel |-> clk_en);

   p_nopll_slow_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (rd_data[1:0] == 2'b10 && $past(rd_data[1:0]) == 2'b10) |-> !fast_sel);

endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.RELOAD_W(RELOAD_W)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .rd_data   (rd_data),
   .clk_en    (clk_en),
   .pll_en    (pll_en),
   .wr_locked (wr_locked),
   .fast_sel  (fast_sel),
   .relock    (relock),
   .lock_st   (lock_st),
   .div_tick  (div_tick)
);

// File: tb/clkmode_ctrl_tb.sv
`timescale 1ns/1ps
module clkmode_ctrl_tb;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        init_done = 1'b0;
   logic        lock_in = 1'b0;
   logic [15:0] rd_data;
   logic        clk_en, pll_en, rtc_async_sel, pd_ports_off, wr_locked;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   clkmode_ctrl u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .init_done(init_done), .lock_in(lock_in), .rd_data(rd_data), .clk_en(clk_en),
      .pll_en(pll_en), .rtc_async_sel(rtc_async_sel), .pd_ports_off(pd_ports_off),
      .wr_locked(wr_locked)
   );

   // {write value, expected readback, expected pll_en}; lock_in held at 1
   localparam logic [32:0] VEC [6] = '{
      {16'h0500, 16'h0540, 1'b1},
      {16'h0201, 16'h0241, 1'b1},
      {16'h0012, 16'h0052, 1'b0},
      {16'h0723, 16'h0762, 1'b0},
      {16'h0004, 16'h0044, 1'b1},
      {16'h0000, 16'h0040, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic count_en(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (clk_en) c++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd", rd_data, 16'h0300);
      chk("R1 pll", pll_en, 1'b1);
      chk("R1 lock", wr_locked, 1'b0);
      count_en(6, c);
      chk("R1 clk_en", c, 6);

      // R6 bit 6 read-only and synchronized
      wr(16'h0040);
      chk("R6 ro", rd_data, 16'h0000);
      lock_in = 1'b1;
      @(negedge clk);
      chk("R6 edge1", rd_data[6], 1'b0);
      @(negedge clk);
      chk("R6 edge2", rd_data[6], 1'b1);

      // table walk: R2 reserved code, R3 pll enable
      foreach (VEC[i]) begin
         wr(VEC[i][32:17]);
         chk("R2 table rd", rd_data, VEC[i][16:1]);
         chk("R3 table pll", pll_en, VEC[i][0]);
      end

      // R9 decoded outputs
      wr(16'h0014);
      chk("R9 rtc", rtc_async_sel, 1'b1);
      chk("R9 pd", pd_ports_off, 1'b1);
      wr(16'h0020);
      chk("R9 pd hi only", pd_ports_off, 1'b0);

      // R5 slowdown divider
      wr(16'h0201);
      repeat (10) @(negedge clk);
      count_en(30, c);
      chk("R5 reload2", c, 10);
      wr(16'h0401);
      repeat (10) @(negedge clk);
      count_en(30, c);
      chk("R5 reload4", c, 6);
      wr(16'h0002);
      repeat (4) @(negedge clk);
      count_en(30, c);
      chk("R5 reload0", c, 30);

      // R4 return from PLL-off waits for lock
      lock_in = 1'b0;
      wr(16'h0112);
      repeat (3) @(negedge clk);
      chk("R4 pll off", pll_en, 1'b0);
      wr(16'h0100);
      repeat (4) @(negedge clk);
      chk("R4 pll on", pll_en, 1'b1);
      count_en(10, c);
      chk("R4 waiting", c, 5);
      lock_in = 1'b1;
      repeat (5) @(negedge clk);
      count_en(10, c);
      chk("R4 fast", c, 10);

      // R10 from 01 to 00 without lock
      lock_in = 1'b0;
      repeat (3) @(negedge clk);
      wr(16'h0301);
      repeat (3) @(negedge clk);
      wr(16'h0300);
      count_en(8, c);
      chk("R10 fast", c, 8);

      // R7 write together with init_done, then locked
      wr(16'h050C);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h010D; init_done = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; init_done = 1'b0;
      chk("R7 same cycle", rd_data, 16'h010D);
      chk("R7 locked", wr_locked, 1'b1);
      wr(16'h0000);
      chk("R7 dropped", rd_data, 16'h010D);

      // R8 system reset keeps clock-source bits
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R8 rd", rd_data, 16'h030C);
      chk("R8 unlock", wr_locked, 1'b0);
      wr(16'h0000);
      chk("R8 writable", rd_data, 16'h0000);
      wr(16'h0004);
      @(negedge clk);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      chk("R8 por", rd_data, 16'h0300);
      chk("R8 por rtc", rtc_async_sel, 1'b0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule